// File: doc/BRIEF.md
# Terminal Line Receive Register with Dataset Control

This block is the receive half of one line of a multi-line asynchronous terminal interface. It holds a receive status register and a receive buffer register, both reached over a small word-addressed register bus. A received character, or a received break, lands in the buffer and sets a done flag. A receive request goes to the interrupt logic when interrupts are enabled. A character that arrives before software has read the previous one is tagged as an overrun.

When the static `modem_en` input is high, the block also models the dataset handshake. Software drives data-terminal-ready, request-to-send and a secondary transmit bit. The block reports ring, clear-to-send and carrier detect, and it latches a dataset-change flag whenever the line state moves. The flag raises a dataset-change request when its enable bit is set. Reading the status register returns its value and then clears the flag.

The dataset state lives in a three-state machine. The states are LINE_OFFLINE (no connection), LINE_RINGING (a connection is waiting with terminal-ready low) and LINE_CARRIER (connected with terminal-ready high). The transitions are:
- OFFLINE to RINGING on a connect event while terminal-ready is low.
- OFFLINE to CARRIER on a connect event while terminal-ready is high.
- RINGING to CARRIER when software raises terminal-ready.
- RINGING to OFFLINE on a disconnect.
- CARRIER to OFFLINE on a disconnect or when software drops terminal-ready (hangup).
- Any state to OFFLINE on a line clear or while modem control is off.

Every transition that enters RINGING or CARRIER, or that leaves CARRIER, is a dataset change.

Top module: `rx_modem_csr`

## Requirements
- R1: The status word (bus_sel=0) has bit 15 dataset-change, 14 ring, 13 clear-to-send, 12 carrier, 10 secondary receive, 7 done, 6 interrupt enable, 5 dataset interrupt enable, 3 secondary transmit, 2 request-to-send and 1 terminal-ready; all other bits read 0. With modem_en=0 only bits 7 and 6 are visible.
- R2: A status write on the even byte stores bit 6 only when modem_en=0. It stores bits 6, 5, 3, 2 and 1 when modem_en=1. A write with bus_odd=1 changes nothing.
- R3: The buffer word (bus_sel=1) holds error in bit 15, overrun in bit 14, break in bit 13 and the character in bits 7:0. A received character sets done and, if interrupt enable is 1, raises rx_req.
- R4: Reading the buffer clears done and withdraws rx_req.
- R5: A character that arrives while done is set is stored with error and overrun set.
- R6: A received break is stored with error and break set and data 0.
- R7: Writing interrupt enable 0 withdraws rx_req; writing it 1 while done is set raises rx_req.
- R8: A connect event with terminal-ready set gives carrier, clear-to-send and dataset-change; with terminal-ready clear it gives ring and dataset-change. ds_req rises if dataset interrupt enable is 1.
- R9: Raising terminal-ready while ringing clears ring and sets carrier, clear-to-send and dataset-change. ds_req follows the dataset interrupt enable value written in the same word.
- R10: Dropping terminal-ready, or a disconnect, while carrier is set sets dataset-change and clears carrier, ring and clear-to-send.
- R11: Reading the status word clears dataset-change and ds_req. Writing dataset interrupt enable 0 withdraws ds_req; writing it 1 while dataset-change is set raises ds_req.
- R12: A line clear empties the buffer and clears rx_req and ds_req. With modem_en=1 it keeps terminal-ready and clears every other status bit; with modem_en=0 it clears the whole status word.
- R13: A character that arrives in the same cycle as a buffer read wins: done stays set, rx_req stays raised if enabled, and the new character is stored without overrun.
- R14: With modem_en=0, connect and disconnect events never set dataset-change or ds_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| modem_en | input | 1 | Static: dataset control enabled |
| line_clr | input | 1 | Synchronous line clear |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | 0 = status word, 1 = buffer word |
| bus_odd | input | 1 | Write targets the odd (high) byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected word |
| char_stb | input | 1 | Received character strobe |
| char_data | input | DATA_W | Received character |
| brk_stb | input | 1 | Received break strobe |
| sec_rx | input | 1 | Secondary receive level |
| line_conn | input | 1 | Line connected event |
| line_disc | input | 1 | Line disconnected event |
| rx_req | output | 1 | Receive request |
| ds_req | output | 1 | Dataset-change request |

## Verification
The assertions watch on every cycle the invariants that tie state across the submodules:
- a receive request never stands without done, and a dataset request never without the change flag;
- overrun always carries error, and break always carries error with zero data;
- carrier never stands without terminal-ready;
- a status read with no competing event clears the change flag;
- the block stays quiet with modem control off.

Only the bench scenarios can show the register masks, the handshake sequences through ringing, carrier and hangup, and the same-cycle read-versus-arrival priority. They also cover the clear rule that keeps terminal-ready, and the fact that odd-byte writes have no effect.

// File: rtl/rxm_pkg.sv
package rxm_pkg;
    localparam int WORD_W = 16;

    // status word bit positions
    localparam int ST_DSCHG = 15;
    localparam int ST_RING  = 14;
    localparam int ST_CTS   = 13;
    localparam int ST_CD    = 12;
    localparam int ST_SECRX = 10;
    localparam int ST_DONE  = 7;
    localparam int ST_IE    = 6;
    localparam int ST_DSIE  = 5;
    localparam int ST_SECTX = 3;
    localparam int ST_RTS   = 2;
    localparam int ST_DTR   = 1;

    // buffer word flag positions
    localparam int BF_ERR = 15;
    localparam int BF_OVR = 14;
    localparam int BF_BRK = 13;

    typedef enum logic [1:0] {
        LINE_OFFLINE = 2'd0,
        LINE_RINGING = 2'd1,
        LINE_CARRIER = 2'd2
    } line_state_e;
endpackage

// File: rtl/rxm_line_fsm.sv
module rxm_line_fsm
    import rxm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic modem_en,
    input  logic line_conn,
    input  logic line_disc,
    input  logic dtr_q,
    input  logic dtr_rise,
    input  logic dtr_fall,
    output logic ring,
    output logic carrier,
    output logic ds_evt
);
    line_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINE_OFFLINE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        ds_evt  = 1'b0;
        if (!modem_en || clr) begin
            state_d = LINE_OFFLINE;
        end else begin
            unique case (state_q)
                LINE_OFFLINE: begin
                    if (line_conn && !line_disc) begin
                        state_d = dtr_q ? LINE_CARRIER : LINE_RINGING;
                        ds_evt  = 1'b1;
                    end
                end
                LINE_RINGING: begin
                    if (line_disc) begin
                        state_d = LINE_OFFLINE;
                    end else if (dtr_rise) begin
                        state_d = LINE_CARRIER;
                        ds_evt  = 1'b1;
                    end
                end
                LINE_CARRIER: begin
                    if (line_disc || dtr_fall) begin
                        state_d = LINE_OFFLINE;
                        ds_evt  = 1'b1;
                    end
                end
                default: state_d = LINE_OFFLINE;
            endcase
        end
    end

    assign ring    = (state_q == LINE_RINGING);
    assign carrier = (state_q == LINE_CARRIER);

    assert_carrier_needs_dtr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        carrier |-> dtr_q);
endmodule

// File: rtl/rxm_rxbuf.sv
module rxm_rxbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              char_stb,
    input  logic [DATA_W-1:0] char_data,
    input  logic              brk_stb,
    input  logic              rd_buf,
    output logic [DATA_W-1:0] data_q,
    output logic              err_q,
    output logic              ovr_q,
    output logic              brk_q,
    output logic              done_q,
    output logic              arrive
);
    logic ovr_tag;

    assign arrive  = char_stb || brk_stb;
    assign ovr_tag = done_q && !rd_buf;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0; err_q <= 1'b0; ovr_q <= 1'b0; brk_q <= 1'b0; done_q <= 1'b0;
        end else if (clr) begin
            data_q <= '0; err_q <= 1'b0; ovr_q <= 1'b0; brk_q <= 1'b0; done_q <= 1'b0;
        end else if (arrive) begin
            done_q <= 1'b1;
            ovr_q  <= ovr_tag;
            if (brk_stb) begin
                data_q <= '0;
                err_q  <= 1'b1;
                brk_q  <= 1'b1;
            end else begin
                data_q <= char_data;
                err_q  <= ovr_tag;
                brk_q  <= 1'b0;
            end
        end else if (rd_buf) begin
            done_q <= 1'b0;
        end
    end

    assert_ovr_marks_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q |-> err_q);
    assert_break_zero_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        brk_q |-> (err_q && data_q == '0));
    assert_arrival_sets_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (arrive && !clr) |=> done_q);
endmodule

// File: rtl/rxm_ctrl.sv
module rxm_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic modem_en,
    input  logic st_wr,
    input  logic st_rd,
    input  logic rd_buf,
    input  logic wr_ie,
    input  logic wr_dsie,
    input  logic wr_sectx,
    input  logic wr_rts,
    input  logic wr_dtr,
    input  logic done_q,
    input  logic arrive,
    input  logic ds_evt,
    output logic ie_q,
    output logic dsie_q,
    output logic sectx_q,
    output logic rts_q,
    output logic dtr_q,
    output logic dsi_q,
    output logic dtr_rise,
    output logic dtr_fall,
    output logic rx_req,
    output logic ds_req
);
    logic ie_eff, dsie_eff, mwr;

    assign mwr      = st_wr && modem_en;
    assign ie_eff   = st_wr ? wr_ie : ie_q;
    assign dsie_eff = mwr ? wr_dsie : dsie_q;
    assign dtr_rise = mwr && wr_dtr && !dtr_q;
    assign dtr_fall = mwr && !wr_dtr && dtr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q <= 1'b0; dsie_q <= 1'b0; sectx_q <= 1'b0; rts_q <= 1'b0; dtr_q <= 1'b0;
            dsi_q <= 1'b0; rx_req <= 1'b0; ds_req <= 1'b0;
        end else if (clr) begin
            ie_q <= 1'b0; dsie_q <= 1'b0; sectx_q <= 1'b0; rts_q <= 1'b0;
            dtr_q <= modem_en && dtr_q;
            dsi_q <= 1'b0; rx_req <= 1'b0; ds_req <= 1'b0;
        end else begin
            if (st_wr) ie_q <= wr_ie;
            if (mwr) begin
                dsie_q  <= wr_dsie;
                sectx_q <= wr_sectx;
                rts_q   <= wr_rts;
                dtr_q   <= wr_dtr;
            end
            if (ds_evt)     dsi_q <= 1'b1;
            else if (st_rd) dsi_q <= 1'b0;

            if (arrive && ie_eff) rx_req <= 1'b1;
            else if (rd_buf)      rx_req <= 1'b0;
            else if (st_wr)       rx_req <= wr_ie && done_q;

            if (ds_evt && dsie_eff) ds_req <= 1'b1;
            else if (st_rd)         ds_req <= 1'b0;
            else if (mwr)           ds_req <= wr_dsie && dsi_q;
        end
    end

    assert_rxreq_needs_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_req |-> done_q);
    assert_dsreq_needs_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ds_req |-> dsi_q);
    assert_read_clears_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_rd && !ds_evt && !clr) |=> !dsi_q);
    assert_nomodem_quiet_R14: assert property (@(posedge clk) disable iff (!rst_n)
        !modem_en |-> !ds_req);
endmodule

// File: rtl/rx_modem_csr.sv
module rx_modem_csr
    import rxm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              modem_en,
    input  logic              line_clr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_sel,
    input  logic              bus_odd,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              char_stb,
    input  logic [DATA_W-1:0] char_data,
    input  logic              brk_stb,
    input  logic              sec_rx,
    input  logic              line_conn,
    input  logic              line_disc,
    output logic              rx_req,
    output logic              ds_req
);
    localparam int PAD_W = BF_BRK - DATA_W;

    logic st_rd, st_wr, rd_buf;
    logic [DATA_W-1:0] data_q;
    logic err_q, ovr_q, brk_q, done_q, arrive;
    logic ie_q, dsie_q, sectx_q, rts_q, dtr_q, dsi_q, dtr_rise, dtr_fall;
    logic ring, carrier, ds_evt;
    logic [WORD_W-1:0] st_word, bf_word;
    logic unused_wbits;

    assign st_rd  = bus_rd && !bus_sel;
    assign rd_buf = bus_rd && bus_sel;
    assign st_wr  = bus_wr && !bus_sel && !bus_odd;
    assign unused_wbits = ^{bus_wdata[15:7], bus_wdata[4], bus_wdata[0]};

    rxm_rxbuf #(.DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(line_clr),
        .char_stb(char_stb), .char_data(char_data), .brk_stb(brk_stb),
        .rd_buf(rd_buf), .data_q(data_q), .err_q(err_q), .ovr_q(ovr_q),
        .brk_q(brk_q), .done_q(done_q), .arrive(arrive)
    );

    rxm_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .clr(line_clr), .modem_en(modem_en),
        .st_wr(st_wr), .st_rd(st_rd), .rd_buf(rd_buf),
        .wr_ie(bus_wdata[ST_IE]), .wr_dsie(bus_wdata[ST_DSIE]),
        .wr_sectx(bus_wdata[ST_SECTX]), .wr_rts(bus_wdata[ST_RTS]),
        .wr_dtr(bus_wdata[ST_DTR]),
        .done_q(done_q), .arrive(arrive), .ds_evt(ds_evt),
        .ie_q(ie_q), .dsie_q(dsie_q), .sectx_q(sectx_q), .rts_q(rts_q),
        .dtr_q(dtr_q), .dsi_q(dsi_q), .dtr_rise(dtr_rise), .dtr_fall(dtr_fall),
        .rx_req(rx_req), .ds_req(ds_req)
    );

    rxm_line_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .clr(line_clr), .modem_en(modem_en),
        .line_conn(line_conn), .line_disc(line_disc), .dtr_q(dtr_q),
        .dtr_rise(dtr_rise), .dtr_fall(dtr_fall),
        .ring(ring), .carrier(carrier), .ds_evt(ds_evt)
    );

    always_comb begin
        st_word = '0;
        st_word[ST_DONE] = done_q;
        st_word[ST_IE]   = ie_q;
        if (modem_en) begin
            st_word[ST_DSCHG] = dsi_q;
            st_word[ST_RING]  = ring;
            st_word[ST_CTS]   = carrier;
            st_word[ST_CD]    = carrier;
            st_word[ST_SECRX] = sec_rx;
            st_word[ST_DSIE]  = dsie_q;
            st_word[ST_SECTX] = sectx_q;
            st_word[ST_RTS]   = rts_q;
            st_word[ST_DTR]   = dtr_q;
        end
    end

    assign bf_word   = {err_q, ovr_q, brk_q, {PAD_W{1'b0}}, data_q};
    assign bus_rdata = bus_sel ? bf_word : st_word;
endmodule

// File: tb/rx_modem_csr_bench.sv
`timescale 1ns/1ps
module rx_modem_csr_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0, modem_en = 1'b0, line_clr = 1'b0;
    logic bus_rd = 1'b0, bus_wr = 1'b0, bus_sel = 1'b0, bus_odd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic char_stb = 1'b0, brk_stb = 1'b0, sec_rx = 1'b0;
    logic [7:0] char_data = '0;
    logic line_conn = 1'b0, line_disc = 1'b0;
    logic rx_req, ds_req;
    int n_vec = 0, n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rx_modem_csr u_rx_modem_csr (
        .clk(clk), .rst_n(rst_n), .modem_en(modem_en), .line_clr(line_clr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_odd(bus_odd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .char_stb(char_stb), .char_data(char_data), .brk_stb(brk_stb),
        .sec_rx(sec_rx), .line_conn(line_conn), .line_disc(line_disc),
        .rx_req(rx_req), .ds_req(ds_req)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic rd(input logic sel, output logic [15:0] v);
        bus_sel = sel; bus_rd = 1'b1; #1; v = bus_rdata;
        step(); bus_rd = 1'b0;
    endtask

    task automatic wr(input logic odd, input logic [15:0] d);
        bus_sel = 1'b0; bus_odd = odd; bus_wdata = d; bus_wr = 1'b1;
        step(); bus_wr = 1'b0; bus_odd = 1'b0;
    endtask

    task automatic rx_char(input logic [7:0] d);
        char_data = d; char_stb = 1'b1; step(); char_stb = 1'b0;
    endtask

    task automatic rx_brk();
        brk_stb = 1'b1; step(); brk_stb = 1'b0;
    endtask

    task automatic conn();
        line_conn = 1'b1; step(); line_conn = 1'b0;
    endtask

    task automatic disc();
        line_disc = 1'b1; step(); line_disc = 1'b0;
    endtask

    task automatic clear_line();
        line_clr = 1'b1; step(); line_clr = 1'b0;
    endtask

    task automatic apply_reset(input logic m);
        rst_n = 1'b0; modem_en = m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; step();
    endtask

    task automatic t_reset_state();
        logic [15:0] v;
        rd(1'b0, v); check("R12 reset status", v, 16'h0000);
        rd(1'b1, v); check("R12 reset buffer", v, 16'h0000);
        check("R12 reset requests", {14'd0, rx_req, ds_req}, 16'h0000);
    endtask

    task automatic t_basic_receive();
        logic [15:0] v;
        wr(1'b0, 16'h0040);
        rd(1'b0, v); check("R2 IE stored", v, 16'h0040);
        rx_char(8'h41);
        check("R3 rx_req raised", {15'd0, rx_req}, 16'h0001);
        rd(1'b0, v); check("R1 status shows done", v, 16'h00C0);
        rd(1'b1, v); check("R3 buffer char", v, 16'h0041);
        check("R4 rx_req withdrawn", {15'd0, rx_req}, 16'h0000);
        rd(1'b0, v); check("R4 done cleared", v, 16'h0040);
        wr(1'b0, 16'hFFFF);
        rd(1'b0, v); check("R1 R2 plain-mode mask", v, 16'h0040);
        wr(1'b0, 16'h0040);
    endtask

    task automatic t_overrun_and_ie();
        logic [15:0] v;
        wr(1'b0, 16'h0000);
        rx_char(8'h12);
        rx_char(8'h34);
        check("R3 no req with IE off", {15'd0, rx_req}, 16'h0000);
        wr(1'b0, 16'h0040);
        check("R7 IE set with done raises", {15'd0, rx_req}, 16'h0001);
        wr(1'b0, 16'h0000);
        check("R7 IE clear withdraws", {15'd0, rx_req}, 16'h0000);
        wr(1'b0, 16'h0040);
        wr(1'b1, 16'h0000);
        check("R2 odd write keeps req", {15'd0, rx_req}, 16'h0001);
        rd(1'b0, v); check("R2 odd write keeps status", v, 16'h00C0);
        rd(1'b1, v); check("R5 overrun tagged", v, 16'hC034);
    endtask

    task automatic t_break();
        logic [15:0] v;
        rx_brk();
        check("R6 break raises req", {15'd0, rx_req}, 16'h0001);
        rd(1'b1, v); check("R6 break word", v, 16'hA000);
    endtask

    task automatic t_read_vs_arrival();
        logic [15:0] v;
        rx_char(8'h55);
        bus_sel = 1'b1; bus_rd = 1'b1; char_data = 8'h66; char_stb = 1'b1;
        #1; v = bus_rdata;
        step(); bus_rd = 1'b0; char_stb = 1'b0;
        check("R13 read returns old char", v, 16'h0055);
        check("R13 req kept", {15'd0, rx_req}, 16'h0001);
        rd(1'b0, v); check("R13 done kept", v, 16'h00C0);
        rd(1'b1, v); check("R13 new char no overrun", v, 16'h0066);
    endtask

    task automatic t_plain_events();
        logic [15:0] v;
        conn();
        check("R14 connect quiet", {15'd0, ds_req}, 16'h0000);
        wr(1'b0, 16'h0062);
        disc();
        check("R14 disconnect quiet", {15'd0, ds_req}, 16'h0000);
        rd(1'b0, v); check("R14 R1 status masked", v, 16'h0040);
    endtask

    task automatic t_plain_clear();
        logic [15:0] v;
        rx_char(8'h77);
        clear_line();
        rd(1'b0, v); check("R12 plain clear status", v, 16'h0000);
        rd(1'b1, v); check("R12 clear buffer", v, 16'h0000);
        check("R12 clear rx_req", {15'd0, rx_req}, 16'h0000);
    endtask

    task automatic t_modem_masks();
        logic [15:0] v;
        wr(1'b0, 16'hFFFF);
        rd(1'b0, v); check("R2 modem writable bits", v, 16'h006E);
        wr(1'b0, 16'h0020);
        rd(1'b0, v); check("R2 offline DTR drop silent", v, 16'h0020);
        check("R10 no change offline", {15'd0, ds_req}, 16'h0000);
    endtask

    task automatic t_ring_then_answer();
        logic [15:0] v;
        conn();
        check("R8 ring raises ds_req", {15'd0, ds_req}, 16'h0001);
        rd(1'b0, v); check("R8 ring status", v, 16'hC020);
        check("R11 read withdraws ds_req", {15'd0, ds_req}, 16'h0000);
        rd(1'b0, v); check("R11 read clears flag", v, 16'h4020);
        wr(1'b0, 16'h0022);
        check("R9 answer raises ds_req", {15'd0, ds_req}, 16'h0001);
        rd(1'b0, v); check("R9 carrier status", v, 16'hB022);
        rd(1'b0, v); check("R9 after read", v, 16'h3022);
    endtask

    task automatic t_hangup_and_dsie();
        logic [15:0] v;
        wr(1'b0, 16'h0000);
        check("R10 hangup with DSIE 0 no req", {15'd0, ds_req}, 16'h0000);
        wr(1'b0, 16'h0020);
        check("R11 DSIE set with flag raises", {15'd0, ds_req}, 16'h0001);
        wr(1'b0, 16'h0000);
        check("R11 DSIE clear withdraws", {15'd0, ds_req}, 16'h0000);
        rd(1'b0, v); check("R10 hangup status", v, 16'h8000);
        rd(1'b0, v); check("R11 flag cleared", v, 16'h0000);
    endtask

    task automatic t_connect_with_dtr();
        logic [15:0] v;
        wr(1'b0, 16'h0022);
        check("R8 DTR offline no req", {15'd0, ds_req}, 16'h0000);
        conn();
        check("R8 carrier raises ds_req", {15'd0, ds_req}, 16'h0001);
        rd(1'b0, v); check("R8 carrier on connect", v, 16'hB022);
        disc();
        check("R10 disconnect raises ds_req", {15'd0, ds_req}, 16'h0001);
        rd(1'b0, v); check("R10 disconnect status", v, 16'h8022);
        rd(1'b0, v); check("R11 cleared after read", v, 16'h0022);
    endtask

    task automatic t_modem_clear();
        logic [15:0] v;
        conn();
        wr(1'b0, 16'h0062);
        rx_char(8'h11);
        clear_line();
        rd(1'b0, v); check("R12 modem clear keeps DTR", v, 16'h0002);
        rd(1'b1, v); check("R12 modem clear buffer", v, 16'h0000);
        check("R12 modem clear requests", {14'd0, rx_req, ds_req}, 16'h0000);
    endtask

    initial begin
        apply_reset(1'b0);
        t_reset_state();
        t_basic_receive();
        t_overrun_and_ie();
        t_break();
        t_read_vs_arrival();
        t_plain_events();
        t_plain_clear();
        apply_reset(1'b1);
        t_reset_state();
        t_modem_masks();
        t_ring_then_answer();
        t_hangup_and_dsie();
        t_connect_with_dtr();
        t_modem_clear();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_vec++; n_bad++;
            $display("FAIL watchdog: got %h expected %h", 16'h0000, 16'h0001);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule